// File: doc/BRIEF.md
# Byte ALU with Decimal-Adjust Flags

This block is the combinational arithmetic and logic unit of a small 8-bit microcontroller core. In one cycle it takes the accumulator byte, a second operand byte, the incoming carry and auxiliary-carry flags and a 4-bit operation code. It returns the result byte and the carry (C), auxiliary carry (AC) and overflow (OV) flags.

Each flag comes with a write-enable, so the surrounding core can tell which flags the selected operation writes. The core stores only those flags in its status register.

The block has no state. Binary addition and subtraction share one carry chain, which also yields the nibble carry and the bit-6 carry. A separate two-stage correction chain turns a binary sum of two packed-BCD bytes into a BCD result. Logical operations, rotates, the nibble swap, increment and decrement come from a third unit. The operation code decides which result and which flags reach the ports.

Top module: `bcd_alu8`

## Requirements
- R1: Operation code 0 (plain add) returns (acc + opnd) mod 256 and ignores c_i. C is 1 exactly when the unsigned sum exceeds 255.
- R2: Operation code 1 (add with carry) adds c_i as well. AC is 1 exactly when acc[3:0] + opnd[3:0] plus the carry-in used by the operation exceeds 15. This AC rule applies to codes 0 and 1.
- R3: For codes 0, 1 and 2, OV is 1 exactly when the carries (borrows for code 2) out of bit 6 and bit 7 differ. This is the same as the signed result leaving -128..+127.
- R4: Operation code 2 returns (acc - opnd - c_i) mod 256. C is 1 when a borrow out of bit 7 is needed (acc < opnd + c_i). AC is 1 when a borrow out of bit 3 is needed (acc[3:0] < opnd[3:0] + c_i).
- R5: Operation code 3 (decimal adjust) works in two steps. First it adds 0x06 when ac_i is 1 or acc[3:0] > 9. Then it adds 0x60 when c_i is 1, the first step carried out of bit 7, or the high nibble of the first-step byte is above 9. C is the OR of c_i with both step carries. Only C is written.
- R6: Codes 4, 5 and 6 return acc AND, OR and XOR opnd. Code 7 returns the complement of acc. Code 8 returns 0x00. None of these writes a flag.
- R7: Code 9 rotates acc left with bit 7 wrapping to bit 0. Code 11 rotates right with bit 0 wrapping to bit 7. Neither writes C.
- R8: Code 10 rotates left through carry: bit 7 goes to C and c_i goes to bit 0. Code 12 rotates right through carry: bit 0 goes to C and c_i goes to bit 7. Both write C only.
- R9: Code 13 exchanges acc[3:0] with acc[7:4] and writes no flag.
- R10: Code 14 returns acc + 1 and code 15 returns acc - 1, both wrapping at 0xFF/0x00. Neither writes a flag.
- R11: The write-enables are set as follows: all three for codes 0 to 2, C only for codes 3, 10 and 12, none otherwise. A flag whose enable is low is driven with its input value (c_i, ac_i), and OV with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| acc_i | input | 8 | Accumulator byte |
| opnd_i | input | 8 | Second operand byte |
| op_i | input | 4 | Operation code (0..15) |
| c_i | input | 1 | Incoming carry/borrow flag |
| ac_i | input | 1 | Incoming auxiliary carry flag |
| res_o | output | 8 | Result byte |
| c_o | output | 1 | New carry flag |
| ac_o | output | 1 | New auxiliary carry flag |
| ov_o | output | 1 | New overflow flag |
| c_we_o | output | 1 | C is written by this operation |
| ac_we_o | output | 1 | AC is written by this operation |
| ov_we_o | output | 1 | OV is written by this operation |

## Verification
The block holds no state, so a fault in it can only be a wrong carry, a wrong mux leg or a wrong enable. Any such fault appears on the ports in the same cycle the operands are applied. Such errors are hard to see with ordinary operands and only show up at the carry boundaries: nibble carries, bit-6 against bit-7 carries, and decimal corrections that ripple into the high nibble. The stimulus therefore combines those boundary values with a long pseudo-random sweep over all sixteen codes and both incoming flags. Every vector is compared against a signed and unsigned integer model.

// File: rtl/bcd_alu_pkg.sv
package bcd_alu_pkg;
    localparam int DATA_W = 8;
    localparam int NIB_W  = DATA_W / 2;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADDC = 4'd1,
        OP_SUBB = 4'd2,
        OP_DADJ = 4'd3,
        OP_AND  = 4'd4,
        OP_OR   = 4'd5,
        OP_XOR  = 4'd6,
        OP_NOT  = 4'd7,
        OP_ZERO = 4'd8,
        OP_ROL  = 4'd9,
        OP_ROLC = 4'd10,
        OP_ROR  = 4'd11,
        OP_RORC = 4'd12,
        OP_SWAP = 4'd13,
        OP_INC  = 4'd14,
        OP_DEC  = 4'd15
    } alu_op_e;
endpackage

// File: rtl/alu_arith.sv
// Shared add/subtract carry chain with nibble, bit-6 and bit-7 carries.
module alu_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         c_out,
    output logic         ac_out,
    output logic         ov_out
);
    localparam int H = W / 2;

    logic [W-1:0] b_eff;
    logic         cin_eff;
    logic [H:0]   lo_sum;
    logic [W-1:0] low_sum;
    logic [W:0]   full_sum;
    logic         cy3, cy6, cy7;

    always_comb begin
        // Subtraction is a + ~b + ~borrow; carries become inverted borrows.
        b_eff    = sub ? ~b : b;
        cin_eff  = sub ? ~cin : cin;
        lo_sum   = {1'b0, a[H-1:0]} + {1'b0, b_eff[H-1:0]} + (H+1)'(cin_eff);
        low_sum  = {1'b0, a[W-2:0]} + {1'b0, b_eff[W-2:0]} + W'(cin_eff);
        full_sum = {1'b0, a} + {1'b0, b_eff} + (W+1)'(cin_eff);
        cy3      = lo_sum[H];
        cy6      = low_sum[W-1];
        cy7      = full_sum[W];
        sum      = full_sum[W-1:0];
        c_out    = sub ? ~cy7 : cy7;
        ac_out   = sub ? ~cy3 : cy3;
        ov_out   = cy6 ^ cy7;

        if (sub) begin
            p_sub_borrow_r4: assert (c_out == ({1'b0, a} < ({1'b0, b} + (W+1)'(cin))))
                else $error("borrow out of top bit wrong");
        end
    end
endmodule

// File: rtl/alu_decadj.sv
// Two-step packed-BCD correction of a binary sum.
module alu_decadj #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         cin,
    input  logic         acin,
    output logic [W-1:0] res,
    output logic         c_out
);
    localparam int H = W / 2;

    logic         lo_fix, hi_fix, c_mid;
    logic [W:0]   step1;
    logic [W:0]   step2;

    always_comb begin
        lo_fix = acin | (a[H-1:0] > H'(9));
        step1  = {1'b0, a} + (lo_fix ? (W+1)'(6) : '0);
        c_mid  = cin | step1[W];
        hi_fix = c_mid | (step1[W-1:H] > (W-H)'(9));
        step2  = {1'b0, step1[W-1:0]} + (hi_fix ? (W+1)'(6) << H : '0);
        res    = step2[W-1:0];
        c_out  = c_mid | step2[W];
    end
endmodule

// File: rtl/alu_bitops.sv
// Logic, rotate, swap, increment and decrement leg.
module alu_bitops
    import bcd_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    input  logic         cin,
    output logic [W-1:0] res,
    output logic         c_out
);
    localparam int H = W / 2;

    logic [W-1:0] swapped;

    generate
        for (genvar i = 0; i < H; i++) begin : g_swap
            assign swapped[i]     = a[i + H];
            assign swapped[i + H] = a[i];
        end
    endgenerate

    always_comb begin
        res   = a;
        c_out = cin;
        unique case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_NOT:  res = ~a;
            OP_ZERO: res = '0;
            OP_ROL:  res = {a[W-2:0], a[W-1]};
            OP_ROLC: begin
                res   = {a[W-2:0], cin};
                c_out = a[W-1];
            end
            OP_ROR:  res = {a[0], a[W-1:1]};
            OP_RORC: begin
                res   = {cin, a[W-1:1]};
                c_out = a[0];
            end
            OP_SWAP: res = swapped;
            OP_INC:  res = a + W'(1);
            OP_DEC:  res = a - W'(1);
            default: res = a;
        endcase
    end
endmodule

// File: rtl/bcd_alu8.sv
module bcd_alu8
    import bcd_alu_pkg::*;
(
    input  logic [DATA_W-1:0] acc_i,
    input  logic [DATA_W-1:0] opnd_i,
    input  logic [3:0]        op_i,
    input  logic              c_i,
    input  logic              ac_i,
    output logic [DATA_W-1:0] res_o,
    output logic              c_o,
    output logic              ac_o,
    output logic              ov_o,
    output logic              c_we_o,
    output logic              ac_we_o,
    output logic              ov_we_o
);
    alu_op_e           op;
    logic              ar_sub, ar_cin;
    logic [DATA_W-1:0] ar_sum, da_res, bo_res;
    logic              ar_c, ar_ac, ar_ov, da_c, bo_c;

    assign op     = alu_op_e'(op_i);
    assign ar_sub = (op == OP_SUBB);
    assign ar_cin = (op == OP_ADD) ? 1'b0 : c_i;

    alu_arith #(.W(DATA_W)) arith_i (
        .a(acc_i), .b(opnd_i), .sub(ar_sub), .cin(ar_cin),
        .sum(ar_sum), .c_out(ar_c), .ac_out(ar_ac), .ov_out(ar_ov)
    );

    alu_decadj #(.W(DATA_W)) decadj_i (
        .a(acc_i), .cin(c_i), .acin(ac_i), .res(da_res), .c_out(da_c)
    );

    alu_bitops #(.W(DATA_W)) bitops_i (
        .a(acc_i), .b(opnd_i), .op(op), .cin(c_i), .res(bo_res), .c_out(bo_c)
    );

    always_comb begin
        res_o   = bo_res;
        c_o     = c_i;
        ac_o    = ac_i;
        ov_o    = 1'b0;
        c_we_o  = 1'b0;
        ac_we_o = 1'b0;
        ov_we_o = 1'b0;
        unique case (op)
            OP_ADD, OP_ADDC, OP_SUBB: begin
                res_o   = ar_sum;
                c_o     = ar_c;
                ac_o    = ar_ac;
                ov_o    = ar_ov;
                c_we_o  = 1'b1;
                ac_we_o = 1'b1;
                ov_we_o = 1'b1;
            end
            OP_DADJ: begin
                res_o  = da_res;
                c_o    = da_c;
                c_we_o = 1'b1;
            end
            OP_ROLC, OP_RORC: begin
                c_o    = bo_c;
                c_we_o = 1'b1;
            end
            default: ;
        endcase

        if (op == OP_ADD) begin
            p_add_sum_r1: assert ({c_o, res_o} == ({1'b0, acc_i} + {1'b0, opnd_i}))
                else $error("plain add result or carry wrong");
        end
        if (op == OP_DADJ && c_i) begin
            p_dadj_keeps_carry_r5: assert (c_o)
                else $error("decimal adjust dropped incoming carry");
        end
        if (op inside {OP_AND, OP_OR, OP_XOR, OP_NOT, OP_ZERO, OP_SWAP,
                       OP_ROL, OP_ROR, OP_INC, OP_DEC}) begin
            p_no_flag_write_r6: assert (!c_we_o && !ac_we_o && !ov_we_o
                                        && c_o == c_i && ac_o == ac_i)
                else $error("flag touched by a non-flag operation");
        end
        if (op == OP_INC && acc_i == '1) begin
            p_inc_wrap_r10: assert (res_o == '0)
                else $error("increment did not wrap");
        end
        p_ov_only_arith_r3: assert (!ov_o || ov_we_o)
            else $error("overflow asserted without write");
    end
endmodule

// File: tb/bcd_alu8_tb_top.sv
module bcd_alu8_tb_top;
    localparam int CLK_PERIOD = 10;

    typedef struct {
        logic [7:0] res;
        logic       c, ac, ov, cwe, acwe, owe;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] acc_i = '0, opnd_i = '0;
    logic [3:0] op_i = '0;
    logic       c_i = 1'b0, ac_i = 1'b0;
    logic [7:0] res_o;
    logic       c_o, ac_o, ov_o, c_we_o, ac_we_o, ov_we_o;

    exp_t q[$];
    int   n_vec = 0;
    int   n_bad = 0;
    bit   done = 1'b0;
    logic [31:0] lfsr = 32'h1ACE_B00C;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_alu8 dut_i (
        .acc_i(acc_i), .opnd_i(opnd_i), .op_i(op_i), .c_i(c_i), .ac_i(ac_i),
        .res_o(res_o), .c_o(c_o), .ac_o(ac_o), .ov_o(ov_o),
        .c_we_o(c_we_o), .ac_we_o(ac_we_o), .ov_we_o(ov_we_o)
    );

    function automatic string op_tag(logic [3:0] op);
        case (op)
            4'd0: return "R1";
            4'd1: return "R2";
            4'd2: return "R4";
            4'd3: return "R5";
            4'd9, 4'd11: return "R7";
            4'd10, 4'd12: return "R8";
            4'd13: return "R9";
            4'd14, 4'd15: return "R10";
            default: return "R6";
        endcase
    endfunction

    function automatic exp_t model(logic [7:0] a, logic [7:0] b, logic [3:0] op,
                                   logic c, logic ac);
        exp_t e;
        int s, lo, sv, cc, v;
        e.res = a; e.c = c; e.ac = ac; e.ov = 1'b0;
        e.cwe = 1'b0; e.acwe = 1'b0; e.owe = 1'b0; e.tag = op_tag(op);
        case (op)
            4'd0, 4'd1: begin
                cc = (op == 4'd1) ? int'(c) : 0;
                s  = int'(a) + int'(b) + cc;
                lo = int'(a[3:0]) + int'(b[3:0]) + cc;
                sv = int'($signed(a)) + int'($signed(b)) + cc;
                e.res = s[7:0]; e.c = (s > 255); e.ac = (lo > 15);
                e.ov = (sv > 127) || (sv < -128);
                e.cwe = 1'b1; e.acwe = 1'b1; e.owe = 1'b1;
            end
            4'd2: begin
                cc = int'(c);
                s  = int'(a) - int'(b) - cc;
                lo = int'(a[3:0]) - int'(b[3:0]) - cc;
                sv = int'($signed(a)) - int'($signed(b)) - cc;
                e.res = s[7:0]; e.c = (s < 0); e.ac = (lo < 0);
                e.ov = (sv > 127) || (sv < -128);
                e.cwe = 1'b1; e.acwe = 1'b1; e.owe = 1'b1;
            end
            4'd3: begin
                cc = int'(c);
                v  = int'(a);
                if (ac || (v % 16) > 9) v = v + 6;
                if (v > 255) cc = 1;
                v = v % 256;
                if (cc == 1 || (v / 16) > 9) v = v + 96;
                if (v > 255) cc = 1;
                e.res = v[7:0]; e.c = cc[0]; e.cwe = 1'b1;
            end
            4'd4:  e.res = a & b;
            4'd5:  e.res = a | b;
            4'd6:  e.res = a ^ b;
            4'd7:  e.res = 8'hFF - a;
            4'd8:  e.res = 8'h00;
            4'd9:  e.res = {a[6:0], a[7]};
            4'd10: begin e.res = {a[6:0], c}; e.c = a[7]; e.cwe = 1'b1; end
            4'd11: e.res = {a[0], a[7:1]};
            4'd12: begin e.res = {c, a[7:1]}; e.c = a[0]; e.cwe = 1'b1; end
            4'd13: e.res = {a[3:0], a[7:4]};
            4'd14: begin v = (int'(a) + 1) % 256; e.res = v[7:0]; end
            default: begin v = (int'(a) + 255) % 256; e.res = v[7:0]; end
        endcase
        return e;
    endfunction

    // Driver: applies one vector at a rising edge and queues its expectation.
    task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [3:0] op,
                         input logic c, input logic ac, input string tag);
        exp_t e;
        @(posedge clk);
        acc_i = a; opnd_i = b; op_i = op; c_i = c; ac_i = ac;
        e = model(a, b, op, c, ac);
        if (tag != "") e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compares at the falling edge, half a period after the drive.
    always @(negedge clk) begin
        if (!rst && q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            n_vec++;
            if (res_o !== e.res || c_o !== e.c || ac_o !== e.ac || ov_o !== e.ov ||
                c_we_o !== e.cwe || ac_we_o !== e.acwe || ov_we_o !== e.owe) begin
                n_bad++;
                $display("FAIL %s op=%0d a=%h b=%h: got res=%h c=%b ac=%b ov=%b we=%b%b%b exp res=%h c=%b ac=%b ov=%b we=%b%b%b",
                         e.tag, op_i, acc_i, opnd_i, res_o, c_o, ac_o, ov_o,
                         c_we_o, ac_we_o, ov_we_o, e.res, e.c, e.ac, e.ov,
                         e.cwe, e.acwe, e.owe);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst = 1'b0;
        // idle inputs: zero add, no flags set
        apply(8'h00, 8'h00, 4'd0, 1'b0, 1'b0, "R1");
        // R1: carry-in ignored by plain add, full wrap
        apply(8'hFF, 8'h01, 4'd0, 1'b1, 1'b0, "R1");
        apply(8'h12, 8'h34, 4'd0, 1'b1, 1'b1, "R1");
        // R2: carry-in pushes low nibble over 15
        apply(8'h0F, 8'h00, 4'd1, 1'b1, 1'b0, "R2");
        apply(8'hFF, 8'h00, 4'd1, 1'b1, 1'b0, "R2");
        // R3: signed overflow on add and subtract
        apply(8'h7F, 8'h01, 4'd0, 1'b0, 1'b0, "R3");
        apply(8'h80, 8'h80, 4'd0, 1'b0, 1'b0, "R3");
        apply(8'h80, 8'h01, 4'd2, 1'b0, 1'b0, "R3");
        apply(8'h7F, 8'hFF, 4'd2, 1'b0, 1'b0, "R3");
        // R4: borrow boundaries
        apply(8'h00, 8'h01, 4'd2, 1'b0, 1'b0, "R4");
        apply(8'h10, 8'h0F, 4'd2, 1'b1, 1'b0, "R4");
        apply(8'h05, 8'h05, 4'd2, 1'b0, 1'b0, "R4");
        apply(8'h05, 8'h04, 4'd2, 1'b1, 1'b1, "R4");
        // R5: decimal adjust cases
        apply(8'h3C, 8'h00, 4'd3, 1'b0, 1'b0, "R5");
        apply(8'h9A, 8'h00, 4'd3, 1'b0, 1'b0, "R5");
        apply(8'h00, 8'h00, 4'd3, 1'b1, 1'b0, "R5");
        apply(8'h12, 8'h00, 4'd3, 1'b0, 1'b1, "R5");
        apply(8'hFA, 8'h00, 4'd3, 1'b0, 1'b0, "R5");
        apply(8'h99, 8'h00, 4'd3, 1'b0, 1'b0, "R5");
        // R6: logic ops keep incoming flags
        apply(8'hF0, 8'h3C, 4'd4, 1'b1, 1'b1, "R6");
        apply(8'hF0, 8'h3C, 4'd5, 1'b0, 1'b1, "R6");
        apply(8'hF0, 8'h3C, 4'd6, 1'b1, 1'b0, "R6");
        apply(8'hA5, 8'h00, 4'd7, 1'b1, 1'b1, "R6");
        apply(8'hA5, 8'hFF, 4'd8, 1'b1, 1'b0, "R6");
        // R7 / R8: rotates
        apply(8'h81, 8'h00, 4'd9, 1'b0, 1'b0, "R7");
        apply(8'h81, 8'h00, 4'd11, 1'b1, 1'b0, "R7");
        apply(8'h80, 8'h00, 4'd10, 1'b0, 1'b0, "R8");
        apply(8'h01, 8'h00, 4'd12, 1'b1, 1'b0, "R8");
        apply(8'h00, 8'h00, 4'd10, 1'b1, 1'b0, "R8");
        // R9: swap
        apply(8'h3C, 8'h00, 4'd13, 1'b1, 1'b1, "R9");
        // R10: wrap without carry
        apply(8'hFF, 8'h00, 4'd14, 1'b0, 1'b0, "R10");
        apply(8'h00, 8'h00, 4'd15, 1'b0, 1'b1, "R10");
        // R11: enables and pass-through across every code with flags set
        for (int k = 0; k < 16; k++)
            apply(8'h5A, 8'hA5, 4'(k), 1'b1, 1'b1, "R11");
        // pseudo-random sweep over every code
        for (int n = 0; n < 4000; n++) begin
            lfsr = lfsr ^ (lfsr << 13);
            lfsr = lfsr ^ (lfsr >> 17);
            lfsr = lfsr ^ (lfsr << 5);
            apply(lfsr[7:0], lfsr[15:8], 4'(n % 16), lfsr[16], lfsr[17], "");
        end
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: run hung, got unfinished exp finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule